// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block picks one interrupt to serve out of sixteen request lines, each tied to its own priority level. Level 15 is the highest and level 0 the lowest. Each level follows one of three masking rules:

- A non-maskable level is served on its request alone.
- A partly maskable level also needs its own enable bit.
- A fully maskable level needs its own enable bit and the global enable as well.

From the winning level the block forms the handler-table word address. Levels map downward from 0FFFEh, two bytes per level, so level 0 sits at 0FFE0h.

The winner and its address are combinational, so the processor reads them in the cycle it raises the acknowledge strobe. Some levels carry exactly one source. When such a level is acknowledged, the block sends a one-cycle clear pulse back to that level's flag on the next cycle. Levels shared by several sources get no clear pulse, and software resolves and clears those itself. Level 15 is the reset level. It is non-maskable and outranks everything.

Top module: `irq_vector_arb`

## Requirements
- R1: While `irq_o` is high, `vec_o` equals 0FFE0h + 2 × `lvl_o`, so level 15 gives 0FFFEh and level 0 gives 0FFE0h.
- R2: `irq_o` is high exactly when at least one level is eligible, and `lvl_o` is then the highest eligible index.
- R3: A non-maskable level (default: level 15 only, bit 15 of `NMI_MASK`) is eligible whenever its request is high, whatever `ena_i` and `gie_i` hold.
- R4: A partly maskable level (default: level 14 only, bit 14 of `PART_MASK`) is eligible when its request and its own `ena_i` bit are high, and `gie_i` has no effect on it.
- R5: Every other level is eligible only when its request, its own `ena_i` bit and `gie_i` are all high.
- R6: A request on level 15 makes `lvl_o` 15 and `vec_o` 0FFFEh, whatever the other inputs hold.
- R7: With no eligible level, `irq_o` is 0, `lvl_o` is 0 and `vec_o` is 0FFE0h.
- R8: If `ack_i` is high at a clock edge while a single-source level wins (default levels 4 to 11, the set bits of `SINGLE_MASK` = 0FF0h), then `clr_o` holds exactly that level's bit for the following cycle only.
- R9: An acknowledge while a multi-source level wins, or while `irq_o` is low, leaves `clr_o` all zero.
- R10: While `rst_n` is low and after its release, `clr_o` is zero until an acknowledge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 16 | Pending flag for each priority level |
| ena_i | input | 16 | Per-level enable bits |
| gie_i | input | 1 | Global enable, which only affects fully maskable levels |
| ack_i | input | 1 | The processor takes the current winner |
| irq_o | output | 1 | Some level is eligible |
| lvl_o | output | 4 | Winning priority level |
| vec_o | output | 16 | Handler-table word address of the winner |
| clr_o | output | 16 | One-cycle clear pulse for an acknowledged single-source flag |

## Verification
The embedded properties check several behaviours on every cycle:

- The reset level overrides every other level.
- The address stays inside the table and the level index agrees with it.
- A fully maskable level never wins while the global enable is low.
- The clear pulse is at most one-hot, follows an acknowledge, and names the level that was acknowledged.

Only the bench scenarios show the rest:

- The full arbitration outcome against an independent model over random request, enable and global-enable mixes.
- The exact masking behaviour of each class.
- That a multi-source acknowledge or an idle acknowledge produces no pulse.

// File: rtl/irq_vector_arb.sv
module irq_vector_arb #(
  parameter int              NLVL        = 16,
  parameter logic [15:0]     VEC_BASE    = 16'hFFE0,
  parameter logic [NLVL-1:0] NMI_MASK    = 16'h8000,
  parameter logic [NLVL-1:0] PART_MASK   = 16'h4000,
  parameter logic [NLVL-1:0] SINGLE_MASK = 16'h0FF0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLVL-1:0]         req_i,
  input  logic [NLVL-1:0]         ena_i,
  input  logic                    gie_i,
  input  logic                    ack_i,
  output logic                    irq_o,
  output logic [$clog2(NLVL)-1:0] lvl_o,
  output logic [15:0]             vec_o,
  output logic [NLVL-1:0]         clr_o
);
  localparam int LW = $clog2(NLVL);
  localparam logic [NLVL-1:0] FULL_MASK = ~(NMI_MASK | PART_MASK);

  logic [NLVL-1:0] gate, elig;
  logic [LW-1:0]   win;
  logic            hit;

  assign gate = NMI_MASK | (ena_i & (PART_MASK | (FULL_MASK & {NLVL{gie_i}})));
  assign elig = req_i & gate;

  always_comb begin
    win = '0;
    hit = 1'b0;
    for (int i = 0; i < NLVL; i++)
      if (elig[i]) begin
        win = LW'(i);
        hit = 1'b1;
      end
  end

  assign irq_o = hit;
  assign lvl_o = win;
  assign vec_o = VEC_BASE + 16'({win, 1'b0});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      clr_o <= '0;
    else if (ack_i && hit && SINGLE_MASK[win])
      clr_o <= NLVL'(1) << win;
    else
      clr_o <= '0;

  // R6
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[NLVL-1] |-> (irq_o && lvl_o == LW'(NLVL-1)));

  // R1
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o[0] == 1'b0 && vec_o >= VEC_BASE &&
               ((vec_o - VEC_BASE) >> 1) == 16'(lvl_o)));

  // R5
  gie_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !gie_i) |-> !FULL_MASK[lvl_o]);

  // R7
  idle_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (lvl_o == '0 && vec_o == VEC_BASE));

  // R8
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));

  // R8
  clr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && SINGLE_MASK[lvl_o]) |=> clr_o[$past(lvl_o)]);

  // R9
  clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i || !irq_o) |=> (clr_o == '0));
endmodule

// File: tb/sim_irq_vector_arb.sv
module sim_irq_vector_arb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] req = 0, ena = 0;
  logic        gie = 0, ack = 0;
  logic        irq;
  logic [3:0]  lvl;
  logic [15:0] vec, clr;
  int          nchk = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_arb u0 (.clk(clk), .rst_n(rst_n), .req_i(req), .ena_i(ena),
    .gie_i(gie), .ack_i(ack), .irq_o(irq), .lvl_o(lvl), .vec_o(vec), .clr_o(clr));

  function automatic int model(input logic [15:0] r, input logic [15:0] e, input logic g);
    int w = -1;
    for (int i = 0; i < 16; i++) begin
      logic ok;
      if (i == 15) ok = r[i];
      else if (i == 14) ok = r[i] & e[i];
      else ok = r[i] & e[i] & g;
      if (ok) w = i;
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] r, input logic [15:0] e, input logic g);
    int w;
    @(negedge clk);
    req = r; ena = e; gie = g;
    #1;
    w = model(r, e, g);
    if (w < 0) begin
      chk({tag, " R7 irq"}, 32'(irq), 0);
      chk({tag, " R7 vec"}, {12'h0, lvl, vec}, 32'h0000FFE0);
    end else begin
      chk({tag, " R2 irq/lvl"}, {irq, 27'h0, lvl}, {1'b1, 27'h0, 4'(w)});
      chk({tag, " R1 vec"}, 32'(vec), 32'(16'hFFE0 + 16'(2 * w)));
    end
  endtask

  task automatic t_reset;
    chk("R10 clr in reset", 32'(clr), 0);
    apply("R7 idle", 16'h0000, 16'hFFFF, 1);
  endtask

  task automatic t_nmi;
    apply("R3 nmi no enables", 16'h8000, 16'h0000, 0);
    apply("R3 nmi over lower", 16'h80FF, 16'hFFFF, 1);
  endtask

  task automatic t_part;
    apply("R4 part disabled", 16'h4000, 16'h0000, 1);
    apply("R4 part gie low", 16'h4000, 16'h4000, 0);
    apply("R4 part beats full", 16'h4010, 16'hFFFF, 1);
  endtask

  task automatic t_full;
    apply("R5 full gie low", 16'h0F00, 16'hFFFF, 0);
    apply("R5 full no ena", 16'h0F00, 16'h00FF, 1);
    apply("R5 full ok", 16'h0F00, 16'h0300, 1);
    apply("R5 level0", 16'h0001, 16'h0001, 1);
  endtask

  task automatic t_override;
    apply("R6 all pending", 16'hFFFF, 16'hFFFF, 1);
    chk("R6 vec top", 32'(vec), 32'h0000FFFE);
  endtask

  task automatic t_ack_single;
    apply("R8 setup", 16'h0080, 16'h0080, 1);
    ack = 1;
    @(negedge clk); ack = 0; #1;
    chk("R8 clr pulse", 32'(clr), 32'h00000080);
    @(negedge clk); #1;
    chk("R8 clr one cycle", 32'(clr), 0);
  endtask

  task automatic t_ack_multi;
    apply("R9 setup", 16'h1000, 16'h1000, 1);
    ack = 1;
    @(negedge clk); ack = 0; #1;
    chk("R9 multi no clr", 32'(clr), 0);
    apply("R9 idle setup", 16'h0000, 16'h0000, 0);
    ack = 1;
    @(negedge clk); ack = 0; #1;
    chk("R9 idle no clr", 32'(clr), 0);
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++)
      apply("R2 random", 16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset;
    rst_n = 1;
    @(negedge clk); #1;
    chk("R10 clr after release", 32'(clr), 0);
    t_nmi;
    t_part;
    t_full;
    t_override;
    t_ack_single;
    t_ack_multi;
    t_random;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule